// File: doc/BRIEF.md
# Camera Control Frame Decoder

This block sits behind a UART receiver (8 data bits, no parity, one stop bit, normally 115200 baud) and turns the received byte stream into control actions for a thermal camera core. It scans for the start marker 0xAA and reads a command code, a length byte and that many argument bytes. It then checks a one-byte additive checksum and expects the end marker 0x55. A good frame is acted on in the clock edge that accepts its end marker. Two commands are recognised: one fires a single-cycle calibration strobe and the other loads a two-bit palette register.

Every frame that reaches its end marker is answered with a six-byte reply on a ready/valid byte output. The reply echoes the command code and carries a status code. A frame that is cut short, or that is too long, or that has no end marker, is dropped quietly and the parser starts scanning for 0xAA again. A timeout on input gaps, set at run time, also drops a frame that stalls halfway.

Top module: `cmd_frame_decoder`

## Requirements
- R1: After reset the palette output is 0 (white-hot), cal_pulse is low and tx_valid is low. Palette codes are 0 white-hot, 1 black-hot, 2 ironbow and 3 rainbow.
- R2: Bytes are ignored until 0xAA is seen. A frame is then 0xAA, command, length N, N argument bytes, checksum, 0x55. The checksum is (command + N + all argument bytes) mod 256.
- R3: A valid frame with command 0x0C, N = 1 and argument 0x01 raises cal_pulse for exactly one cycle. The pulse follows the clock edge that accepts the 0x55.
- R4: A valid frame with command 0x1F, N = 1 and argument 0..3 loads palette with that value. The new value shows from the clock edge that accepts the 0x55.
- R5: Each frame that ends with 0x55 is answered with the bytes 0xAA, command, 0x01, status, (command + 0x01 + status) mod 256, 0x55. The status is 0x00 when the frame is accepted. tx_valid rises one cycle after the end marker is accepted. While tx_ready is low, tx_valid and tx_data hold.
- R6: A frame with a wrong checksum changes neither cal_pulse nor palette. Its reply carries status 0x01.
- R7: A frame whose closing byte is not 0x55 has no effect and gets no reply. The next frame is decoded normally.
- R8: A length byte above MAX_LEN (16) drops the frame with no effect and no reply. The parser then scans for 0xAA.
- R9: An unknown command, a palette argument above 0x03, a calibration argument other than 0x01, or N different from 1 for either known command leaves all state unchanged. Its reply carries status 0x02.
- R10: If idle_limit is not zero and idle_limit cycles pass with no byte while a frame is open, the frame is dropped. The parser then scans for 0xAA. Shorter gaps are tolerated.
- R11: A frame that completes while a reply is still being sent still takes effect. No reply is sent for it, and the reply in progress goes on unchanged.
- R12: N = MAX_LEN and N = 0 are legal frame lengths and are answered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| idle_limit | input | TO_W | Idle cycles that abort an open frame; 0 disables the timeout |
| rx_valid | input | 1 | A received byte is present this cycle |
| rx_data | input | 8 | Received byte |
| tx_valid | output | 1 | Reply byte available |
| tx_ready | input | 1 | Downstream takes the reply byte |
| tx_data | output | 8 | Reply byte |
| cal_pulse | output | 1 | One-cycle flat-field calibration request |
| palette | output | 2 | Selected output palette |

## Verification
The bench builds the block with MAX_LEN at its default of 16, so one frame of exactly 16 argument bytes and one with a length of 17 test both sides of the length limit. TO_W is set to 8 and idle_limit is driven to 20. This makes a 5-cycle gap and a 40-cycle gap fall clearly on either side of the timeout. USE_IDLE_TIMEOUT stays enabled, so the bench also builds the timer variant. With tx_ready held low, a second frame can complete while the first reply is still pending.

// File: rtl/cfd_pkg.sv
package cfd_pkg;

   localparam logic [7:0] SOF_BYTE    = 8'hAA;
   localparam logic [7:0] EOF_BYTE    = 8'h55;
   localparam logic [7:0] OP_CALIB    = 8'h0C;
   localparam logic [7:0] OP_PALETTE  = 8'h1F;
   localparam logic [7:0] CALIB_ARG   = 8'h01;
   localparam logic [7:0] PAL_TOP     = 8'h03;
   localparam logic [7:0] REPLY_LEN   = 8'h01;

   localparam logic [7:0] STAT_OK     = 8'h00;
   localparam logic [7:0] STAT_CSUM   = 8'h01;
   localparam logic [7:0] STAT_ARG    = 8'h02;

   localparam logic [1:0] PAL_RESET   = 2'd0;

   localparam int REPLY_BYTES = 6;

   typedef enum logic [2:0] {
      P_HUNT,
      P_CMD,
      P_LEN,
      P_DATA,
      P_SUM,
      P_TAIL
   } pstate_t;

   typedef struct packed {
      logic [7:0] cmd;
      logic [7:0] status;
   } reply_t;

endpackage

// File: rtl/cfd_parser.sv
module cfd_parser
   import cfd_pkg::*;
#(
   parameter int MAX_LEN = 16,
   parameter int CNT_W   = $clog2(MAX_LEN + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             byte_vld,
   input  logic [7:0]       byte_val,
   input  logic             abort,
   output logic             in_frame,
   output logic             frame_end,
   output logic [7:0]       cmd_o,
   output logic [CNT_W-1:0] len_o,
   output logic [7:0]       arg_o,
   output logic             sum_ok_o
);

   localparam logic [7:0] LEN_LIMIT = 8'(MAX_LEN);

   if (MAX_LEN < 1 || MAX_LEN > 255) begin : g_bad_len
      $error("cfd_parser: MAX_LEN must lie in 1..255");
   end
   if (CNT_W < 1 || CNT_W > 8) begin : g_bad_cnt
      $error("cfd_parser: CNT_W must lie in 1..8");
   end

   pstate_t          st_q;
   logic [7:0]       cmd_q;
   logic [7:0]       acc_q;
   logic [7:0]       arg_q;
   logic [CNT_W-1:0] len_q;
   logic [CNT_W-1:0] cnt_q;
   logic             sum_ok_q;

   logic [CNT_W-1:0] cnt_nxt;
   logic [7:0]       acc_nxt;

   assign cnt_nxt = cnt_q + CNT_W'(1);
   assign acc_nxt = acc_q + byte_val;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= P_HUNT;
         cmd_q    <= '0;
         acc_q    <= '0;
         arg_q    <= '0;
         len_q    <= '0;
         cnt_q    <= '0;
         sum_ok_q <= 1'b0;
      end else if (abort) begin
         st_q <= P_HUNT;
      end else if (byte_vld) begin
         unique case (st_q)
            P_HUNT: begin
               if (byte_val == SOF_BYTE) st_q <= P_CMD;
            end
            P_CMD: begin
               cmd_q <= byte_val;
               acc_q <= byte_val;
               st_q  <= P_LEN;
            end
            P_LEN: begin
               if (byte_val > LEN_LIMIT) begin
                  st_q <= P_HUNT;
               end else begin
                  len_q <= byte_val[CNT_W-1:0];
                  acc_q <= acc_nxt;
                  cnt_q <= '0;
                  arg_q <= '0;
                  st_q  <= (byte_val == 8'h00) ? P_SUM : P_DATA;
               end
            end
            P_DATA: begin
               if (cnt_q == '0) arg_q <= byte_val;
               acc_q <= acc_nxt;
               cnt_q <= cnt_nxt;
               if (cnt_nxt == len_q) st_q <= P_SUM;
            end
            P_SUM: begin
               sum_ok_q <= (byte_val == acc_q);
               st_q     <= P_TAIL;
            end
            P_TAIL: begin
               st_q <= P_HUNT;
            end
            default: st_q <= P_HUNT;
         endcase
      end
   end

   assign in_frame  = (st_q != P_HUNT);
   assign frame_end = byte_vld && !abort && (st_q == P_TAIL) && (byte_val == EOF_BYTE);
   assign cmd_o     = cmd_q;
   assign len_o     = len_q;
   assign arg_o     = arg_q;
   assign sum_ok_o  = sum_ok_q;

endmodule

// File: rtl/cfd_dispatch.sv
module cfd_dispatch
   import cfd_pkg::*;
#(
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame_end,
   input  logic [7:0]       cmd,
   input  logic [CNT_W-1:0] len,
   input  logic [7:0]       arg,
   input  logic             sum_ok,
   output logic             cal_pulse,
   output logic [1:0]       palette,
   output logic             rsp_go,
   output reply_t           rsp
);

   logic       is_cal;
   logic       is_pal;
   logic       len_one;
   logic       arg_ok;
   logic       accept;
   logic [7:0] status;

   always_comb begin
      is_cal  = (cmd == OP_CALIB);
      is_pal  = (cmd == OP_PALETTE);
      len_one = (len == CNT_W'(1));
      arg_ok  = 1'b0;
      if (is_cal)      arg_ok = len_one && (arg == CALIB_ARG);
      else if (is_pal) arg_ok = len_one && (arg <= PAL_TOP);
      accept  = sum_ok && arg_ok;
      if (!sum_ok)     status = STAT_CSUM;
      else if (arg_ok) status = STAT_OK;
      else             status = STAT_ARG;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cal_pulse <= 1'b0;
         palette   <= PAL_RESET;
         rsp_go    <= 1'b0;
         rsp       <= '0;
      end else begin
         cal_pulse <= frame_end && accept && is_cal;
         rsp_go    <= frame_end;
         if (frame_end) begin
            rsp.cmd    <= cmd;
            rsp.status <= status;
         end
         if (frame_end && accept && is_pal) palette <= arg[1:0];
      end
   end

endmodule

// File: rtl/cfd_idle_timer.sv
module cfd_idle_timer #(
   parameter int TO_W = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            active,
   input  logic            byte_seen,
   input  logic [TO_W-1:0] limit,
   output logic            expire
);

   if (TO_W < 2 || TO_W > 32) begin : g_bad_w
      $error("cfd_idle_timer: TO_W must lie in 2..32");
   end

   logic [TO_W-1:0] idle_q;

   assign expire = active && !byte_seen && (limit != '0) &&
                   (idle_q >= limit - TO_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    idle_q <= '0;
      else if (!active || byte_seen) idle_q <= '0;
      else if (!expire)              idle_q <= idle_q + TO_W'(1);
   end

endmodule

// File: rtl/cfd_reply.sv
module cfd_reply
   import cfd_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       go,
   input  reply_t     rsp,
   input  logic       ready,
   output logic       valid,
   output logic [7:0] data
);

   localparam int              IDX_W = $clog2(REPLY_BYTES);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(REPLY_BYTES - 1);

   logic             busy_q;
   logic [IDX_W-1:0] idx_q;
   reply_t           hold_q;
   logic [7:0]       bytes [REPLY_BYTES];

   always_comb begin
      bytes[0] = SOF_BYTE;
      bytes[1] = hold_q.cmd;
      bytes[2] = REPLY_LEN;
      bytes[3] = hold_q.status;
      bytes[4] = hold_q.cmd + REPLY_LEN + hold_q.status;
      bytes[5] = EOF_BYTE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         idx_q  <= '0;
         hold_q <= '0;
      end else if (!busy_q) begin
         if (go) begin
            busy_q <= 1'b1;
            idx_q  <= '0;
            hold_q <= rsp;
         end
      end else if (ready) begin
         if (idx_q == LAST) busy_q <= 1'b0;
         else               idx_q  <= idx_q + IDX_W'(1);
      end
   end

   assign valid = busy_q;
   assign data  = bytes[idx_q];

endmodule

// File: rtl/cmd_frame_decoder.sv
module cmd_frame_decoder
   import cfd_pkg::*;
#(
   parameter int MAX_LEN          = 16,
   parameter int TO_W             = 16,
   parameter bit USE_IDLE_TIMEOUT = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [TO_W-1:0] idle_limit,
   input  logic            rx_valid,
   input  logic [7:0]      rx_data,
   output logic            tx_valid,
   input  logic            tx_ready,
   output logic [7:0]      tx_data,
   output logic            cal_pulse,
   output logic [1:0]      palette
);

   localparam int CNT_W = $clog2(MAX_LEN + 1);

   logic             in_frame;
   logic             frame_end;
   logic             abort;
   logic [7:0]       f_cmd;
   logic [CNT_W-1:0] f_len;
   logic [7:0]       f_arg;
   logic             f_sum_ok;
   logic             rsp_go;
   reply_t           rsp;

   if (USE_IDLE_TIMEOUT) begin : g_timer
      cfd_idle_timer #(.TO_W(TO_W)) u_timer (
         .clk       (clk),
         .rst_n     (rst_n),
         .active    (in_frame),
         .byte_seen (rx_valid),
         .limit     (idle_limit),
         .expire    (abort)
      );
   end else begin : g_no_timer
      assign abort = 1'b0;
   end

   cfd_parser #(.MAX_LEN(MAX_LEN), .CNT_W(CNT_W)) u_parse (
      .clk       (clk),
      .rst_n     (rst_n),
      .byte_vld  (rx_valid),
      .byte_val  (rx_data),
      .abort     (abort),
      .in_frame  (in_frame),
      .frame_end (frame_end),
      .cmd_o     (f_cmd),
      .len_o     (f_len),
      .arg_o     (f_arg),
      .sum_ok_o  (f_sum_ok)
   );

   cfd_dispatch #(.CNT_W(CNT_W)) u_disp (
      .clk       (clk),
      .rst_n     (rst_n),
      .frame_end (frame_end),
      .cmd       (f_cmd),
      .len       (f_len),
      .arg       (f_arg),
      .sum_ok    (f_sum_ok),
      .cal_pulse (cal_pulse),
      .palette   (palette),
      .rsp_go    (rsp_go),
      .rsp       (rsp)
   );

   cfd_reply u_reply (
      .clk   (clk),
      .rst_n (rst_n),
      .go    (rsp_go),
      .rsp   (rsp),
      .ready (tx_ready),
      .valid (tx_valid),
      .data  (tx_data)
   );

endmodule

// File: rtl/cfd_checker.sv
module cfd_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       rx_valid,
   input logic [7:0] rx_data,
   input logic       tx_valid,
   input logic       tx_ready,
   input logic [7:0] tx_data,
   input logic       cal_pulse,
   input logic [1:0] palette
);

   // R1: state right after reset release
   a_r1_reset_state: assert property (@(posedge clk)
      $rose(rst_n) |-> (palette == 2'd0) && !tx_valid && !cal_pulse);

   // R3: strobe lasts one cycle
   a_r3_cal_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      cal_pulse |=> !cal_pulse);

   // R3: strobe only follows an accepted end marker
   a_r3_cal_after_tail: assert property (@(posedge clk) disable iff (!rst_n)
      cal_pulse |-> $past(rx_valid) && ($past(rx_data) == 8'h55));

   // R4: palette moves only on an accepted end marker
   a_r4_pal_after_tail: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(palette) |-> $past(rx_valid) && ($past(rx_data) == 8'h55));

   // R5: reply byte held under back-pressure
   a_r5_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));

   // R5: every reply opens with the start marker
   a_r5_first_sof: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_valid) |-> (tx_data == 8'hAA));

endmodule

bind cmd_frame_decoder cfd_checker u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .rx_valid  (rx_valid),
   .rx_data   (rx_data),
   .tx_valid  (tx_valid),
   .tx_ready  (tx_ready),
   .tx_data   (tx_data),
   .cal_pulse (cal_pulse),
   .palette   (palette)
);

// File: tb/sim_cmd_frame_decoder.sv
`timescale 1ns/1ps
module sim_cmd_frame_decoder;

   localparam int TO_W = 8;
   localparam logic [7:0] SOF = 8'hAA;
   localparam logic [7:0] EOF = 8'h55;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [TO_W-1:0] idle_limit = 8'd20;
   logic            rx_valid = 1'b0;
   logic [7:0]      rx_data = 8'h00;
   logic            tx_ready = 1'b1;
   logic            tx_valid;
   logic [7:0]      tx_data;
   logic            cal_pulse;
   logic [1:0]      palette;

   int checks = 0;
   int errors = 0;
   logic [7:0] pl [0:16];
   logic [1:0] exp_pal = 2'd0;

   always #5 clk = ~clk;

   cmd_frame_decoder #(.MAX_LEN(16), .TO_W(TO_W), .USE_IDLE_TIMEOUT(1'b1)) u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .idle_limit (idle_limit),
      .rx_valid   (rx_valid),
      .rx_data    (rx_data),
      .tx_valid   (tx_valid),
      .tx_ready   (tx_ready),
      .tx_data    (tx_data),
      .cal_pulse  (cal_pulse),
      .palette    (palette)
   );

   // cmd, arg, bad checksum, status, palette after, cal expected
   localparam int NV = 10;
   localparam logic [27:0] VEC [NV] = '{
      {8'h1F, 8'h02, 1'b0, 8'h00, 2'd2, 1'b0},
      {8'h0C, 8'h01, 1'b0, 8'h00, 2'd2, 1'b1},
      {8'h1F, 8'h03, 1'b0, 8'h00, 2'd3, 1'b0},
      {8'h1F, 8'h01, 1'b0, 8'h00, 2'd1, 1'b0},
      {8'h1F, 8'h04, 1'b0, 8'h02, 2'd1, 1'b0},
      {8'h0C, 8'h00, 1'b0, 8'h02, 2'd1, 1'b0},
      {8'h1F, 8'h00, 1'b1, 8'h01, 2'd1, 1'b0},
      {8'h0C, 8'h01, 1'b1, 8'h01, 2'd1, 1'b0},
      {8'h42, 8'h01, 1'b0, 8'h02, 2'd1, 1'b0},
      {8'h1F, 8'h00, 1'b0, 8'h00, 2'd0, 1'b0}
   };

   task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic send_byte(input logic [7:0] b);
      @(negedge clk);
      rx_valid = 1'b1;
      rx_data  = b;
      @(negedge clk);
      rx_valid = 1'b0;
   endtask

   task automatic send_frame(input logic [7:0] cmd, input int n, input bit bad,
                             input logic [7:0] tail, input int gap);
      logic [7:0] s;
      s = cmd + 8'(n);
      for (int i = 0; i < n; i++) s = s + pl[i];
      if (bad) s = s + 8'h01;
      send_byte(SOF);
      send_byte(cmd);
      repeat (gap) @(negedge clk);
      send_byte(8'(n));
      for (int i = 0; i < n; i++) send_byte(pl[i]);
      send_byte(s);
      send_byte(tail);
   endtask

   task automatic expect_reply(input logic [7:0] cmd, input logic [7:0] st, input string tag);
      logic [47:0] got;
      logic [47:0] exp;
      logic [7:0]  cs;
      cs  = cmd + 8'h01 + st;
      exp = {SOF, cmd, 8'h01, st, cs, EOF};
      got = '0;
      for (int i = 0; i < 6; i++) begin
         int w = 0;
         while (!tx_valid && w < 50) begin
            @(negedge clk);
            w++;
         end
         got = {got[39:0], tx_data};
         @(negedge clk);
      end
      check(got == exp, tag, 64'(got), 64'(exp));
   endtask

   task automatic expect_none(input string tag);
      bit seen = 1'b0;
      repeat (12) begin
         @(negedge clk);
         if (tx_valid) seen = 1'b1;
      end
      check(!seen, tag, 64'(seen), 64'd0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check(palette == 2'd0, "R1 palette", 64'(palette), 64'd0);
      check(!tx_valid && !cal_pulse, "R1 outputs idle", 64'({tx_valid, cal_pulse}), 64'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // vector table
      for (int i = 0; i < NV; i++) begin
         logic [7:0] cmd, arg, st;
         logic       bad, cal;
         logic [1:0] pal;
         string      tag;
         {cmd, arg, bad, st, pal, cal} = VEC[i];
         pl[0] = arg;
         send_frame(cmd, 1, bad, EOF, 0);
         if (st == 8'h02)      tag = "R9";
         else if (st == 8'h01) tag = "R6";
         else if (cmd == 8'h0C) tag = "R3";
         else                  tag = "R4";
         exp_pal = pal;
         check(palette == exp_pal, {tag, " palette"}, 64'(palette), 64'(exp_pal));
         check(cal_pulse == cal, {tag, " cal_pulse"}, 64'(cal_pulse), 64'(cal));
         expect_reply(cmd, st, "R5 reply bytes");
      end

      // R2: noise before the start marker is ignored
      send_byte(8'h12); send_byte(8'h55); send_byte(8'h00); send_byte(8'h1F);
      expect_none("R2 noise no reply");
      pl[0] = 8'h02;
      send_frame(8'h1F, 1, 1'b0, EOF, 0);
      exp_pal = 2'd2;
      check(palette == exp_pal, "R2 frame after noise", 64'(palette), 64'(exp_pal));
      expect_reply(8'h1F, 8'h00, "R2 reply");

      // R7: wrong closing byte
      pl[0] = 8'h03;
      send_frame(8'h1F, 1, 1'b0, 8'h33, 0);
      check(palette == exp_pal, "R7 no effect", 64'(palette), 64'(exp_pal));
      expect_none("R7 no reply");
      pl[0] = 8'h01;
      send_frame(8'h1F, 1, 1'b0, EOF, 0);
      exp_pal = 2'd1;
      check(palette == exp_pal, "R7 next frame", 64'(palette), 64'(exp_pal));
      expect_reply(8'h1F, 8'h00, "R7 next reply");

      // R8: length above 16
      send_byte(SOF); send_byte(8'h1F); send_byte(8'h11);
      send_byte(8'h03); send_byte(8'h33); send_byte(EOF);
      expect_none("R8 no reply");
      check(palette == exp_pal, "R8 no effect", 64'(palette), 64'(exp_pal));

      // R12: length 16 and length 0
      for (int i = 0; i < 16; i++) pl[i] = 8'(i + 1);
      send_frame(8'h1F, 16, 1'b0, EOF, 0);
      check(palette == exp_pal, "R12 len16 palette", 64'(palette), 64'(exp_pal));
      expect_reply(8'h1F, 8'h02, "R12 len16 reply");
      send_frame(8'h0C, 0, 1'b0, EOF, 0);
      check(!cal_pulse, "R12 len0 no cal", 64'(cal_pulse), 64'd0);
      expect_reply(8'h0C, 8'h02, "R12 len0 reply");

      // R10: long gap drops, short gap survives
      pl[0] = 8'h00;
      send_frame(8'h1F, 1, 1'b0, EOF, 40);
      check(palette == exp_pal, "R10 long gap dropped", 64'(palette), 64'(exp_pal));
      expect_none("R10 long gap no reply");
      pl[0] = 8'h03;
      send_frame(8'h1F, 1, 1'b0, EOF, 5);
      exp_pal = 2'd3;
      check(palette == exp_pal, "R10 short gap kept", 64'(palette), 64'(exp_pal));
      expect_reply(8'h1F, 8'h00, "R10 short gap reply");

      // R11 and R5 back-pressure
      tx_ready = 1'b0;
      pl[0] = 8'h01;
      send_frame(8'h0C, 1, 1'b0, EOF, 0);
      check(cal_pulse == 1'b1, "R11 first frame cal", 64'(cal_pulse), 64'd1);
      pl[0] = 8'h02;
      send_frame(8'h1F, 1, 1'b0, EOF, 0);
      exp_pal = 2'd2;
      check(palette == exp_pal, "R11 second frame acts", 64'(palette), 64'(exp_pal));
      repeat (3) @(negedge clk);
      check(tx_valid && tx_data == SOF, "R5 held under back-pressure",
            64'({tx_valid, tx_data}), 64'({1'b1, SOF}));
      tx_ready = 1'b1;
      expect_reply(8'h0C, 8'h00, "R11 pending reply");
      expect_none("R11 no second reply");

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule